// File: doc/BRIEF.md
# Phase-Chained Up-Down PWM Timebase

This block supplies the triangle carriers for four PWM channels. Each channel owns an up-down counter that climbs from zero to its period and falls back to zero, one step per clock. Channel 0 is the master. It never takes a phase load, and it raises a one-cycle sync pulse whenever its counter sits at zero. The sync passes through every slave with no register, so all slaves see it in the same cycle as the master zero.

A slave with phase loading enabled reacts to that sync. On the next clock edge it replaces its counter with its programmed phase count and its direction with its programmed direction. Because the direction is loaded as well as the count, a single phase value of half the period gives a lag of either a quarter or three quarters of a carrier cycle. A phase equal to the period gives half a cycle.

Each channel's period is written into a shadow register. The shadow is copied into the active period only while the counter is at zero. Each channel exposes its count, its direction, its zero and peak flags, and its sync output. Compare, action and dead-band stages sit downstream and are not part of this block.

Top module: `phase_pwm_timebase`

## Requirements
- R1: With period P ≥ 1, a channel that is not loaded steps by exactly one each clock. It runs 0,1,…,P and then P−1,…,0, so one carrier cycle lasts 2·P clocks. The direction output is 1 while the next step is up and 0 while it is down.
- R2: The counter never exceeds the active period, and a period of 0 holds the counter at 0 with direction up.
- R3: A period write goes to the shadow register only. The active period changes only on a clock edge at which that channel's counter is 0, and the step taken from 0 on that edge already uses the new value.
- R4: zero_o of a channel is 1 exactly while its count is 0. prd_o is 1 exactly while its count equals its active period. sync_o[0] equals zero_o[0].
- R5: Sync forwarding is combinational. Every sync_o[c] equals sync_o[0] in the same cycle.
- R6: A slave (c ≥ 1) with phase_en_i[c]=1 that sees sync loads on the next edge. Its count becomes phase_i[c], clamped to the period in force, and its direction becomes phase_dir_i[c], where 1 is up and 0 is down.
- R7: A loaded count of 0 forces direction up. A loaded count equal to a nonzero period forces direction down, whatever phase_dir_i says.
- R8: Channel 0 never loads a phase, whatever its phase_en_i and phase_i inputs hold.
- R9: A slave with phase_en_i[c]=0 ignores sync and keeps counting freely.
- R10: While rst_ni is low, every count is 0, every direction is up, and the shadow and active periods equal the RST_PRD parameter.
- R11: With period P, the following slave phase settings give lags of one quarter, one half and three quarters of a carrier cycle behind the master: P/2 down, P up, and P/2 up. In the cycle after a master zero, the slaves read P/2 down, P down and P/2 up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prd_wr_i | input | N_CH | Per-channel shadow period write strobe |
| prd_wdata_i | input | N_CH×CNT_W | Per-channel shadow period value |
| phase_i | input | N_CH×CNT_W | Per-channel phase count loaded on sync |
| phase_dir_i | input | N_CH | Per-channel direction loaded on sync (1 up) |
| phase_en_i | input | N_CH | Per-channel phase-load enable (ignored on channel 0) |
| cnt_o | output | N_CH×CNT_W | Per-channel counter value |
| dir_o | output | N_CH | Per-channel direction (1 up) |
| zero_o | output | N_CH | Counter equals zero |
| prd_o | output | N_CH | Counter equals active period |
| sync_o | output | N_CH | Per-channel sync output |

## Verification
The assertions assume that a period, once written, is held long enough for the counter to reach zero before its shape is judged. They also assume that phase and direction inputs stay steady across the edge that loads them. The bench meets both conditions by driving every input on the falling clock edge only. It writes periods at least one full carrier cycle before it checks their effect, and it changes phase settings only in the cycle when the master sits at zero. Every cycle, the outputs are compared against a model written from the requirements. Fixed expected values back up the quadrature, clamp, free-run and shadow cases.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/pwm_prd_shadow.sv
module pwm_prd_shadow #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RST_PRD = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             at_zero_i,
  output logic [CNT_W-1:0] prd_nxt_o,
  output logic [CNT_W-1:0] prd_act_o
);
  localparam logic [CNT_W-1:0] RstVal = CNT_W'(RST_PRD);

  logic [CNT_W-1:0] shadow_q, active_q;

  // active period is refreshed only at the zero boundary
  assign prd_nxt_o = at_zero_i ? shadow_q : active_q;
  assign prd_act_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= RstVal;
      active_q <= RstVal;
    end else begin
      if (wr_i) shadow_q <= wdata_i;
      active_q <= prd_nxt_o;
    end
  end

  p_prd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_zero_i |=> $stable(prd_act_o));
endmodule

// File: rtl/pwm_phase_load.sv
module pwm_phase_load
  import phase_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] phase_i,
  input  logic             dir_i,
  input  logic [CNT_W-1:0] prd_i,
  output logic [CNT_W-1:0] val_o,
  output logic             dir_o
);
  always_comb begin
    val_o = (phase_i > prd_i) ? prd_i : phase_i;
    if (val_o == '0)        dir_o = DIR_UP;
    else if (val_o == prd_i) dir_o = DIR_DOWN;
    else                     dir_o = dir_i;
  end

  always_comb begin
    a_clamp_r6: assert (val_o <= prd_i);
  end
endmodule

// File: rtl/pwm_updown_cnt.sv
module pwm_updown_cnt
  import phase_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] prd_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             load_dir_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, cnt_dec;
  logic             dir_q, dir_d, go_up;

  assign cnt_inc = cnt_q + 1'b1;
  assign cnt_dec = cnt_q - 1'b1;
  assign go_up   = ((dir_q == DIR_UP) && (cnt_q < prd_i)) || (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (load_i) begin
      cnt_d = load_val_i;
      dir_d = load_dir_i;
    end else if (prd_i == '0) begin
      cnt_d = '0;
      dir_d = DIR_UP;
    end else if (go_up) begin
      cnt_d = cnt_inc;
      dir_d = (cnt_inc >= prd_i) ? DIR_DOWN : DIR_UP;
    end else begin
      cnt_d = cnt_dec;
      dir_d = (cnt_dec == '0) ? DIR_UP : DIR_DOWN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o = cnt_q;
  assign dir_o = dir_q;

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && prd_i != '0) |=>
      (cnt_o == $past(cnt_o) + 1'b1) || (cnt_o == $past(cnt_o) - 1'b1));

  p_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_o <= $past(prd_i));

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_o == $past(load_val_i)) && (dir_o == $past(load_dir_i)));

  p_zero_up_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o == '0 |-> dir_o == DIR_UP);
endmodule

// File: rtl/phase_pwm_timebase.sv
module phase_pwm_timebase
  import phase_pwm_pkg::*;
#(
  parameter int unsigned N_CH    = 4,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RST_PRD = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_CH-1:0]             prd_wr_i,
  input  logic [N_CH-1:0][CNT_W-1:0]  prd_wdata_i,
  input  logic [N_CH-1:0][CNT_W-1:0]  phase_i,
  input  logic [N_CH-1:0]             phase_dir_i,
  input  logic [N_CH-1:0]             phase_en_i,
  output logic [N_CH-1:0][CNT_W-1:0]  cnt_o,
  output logic [N_CH-1:0]             dir_o,
  output logic [N_CH-1:0]             zero_o,
  output logic [N_CH-1:0]             prd_o,
  output logic [N_CH-1:0]             sync_o
);
  localparam int unsigned LastCh = N_CH - 1;

  logic [N_CH-1:0][CNT_W-1:0] prd_nxt, prd_act, ld_val;
  logic [N_CH-1:0]            ld_dir, ld_en;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pwm_prd_shadow #(.CNT_W(CNT_W), .RST_PRD(RST_PRD)) u_prd (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (prd_wr_i[c]),
      .wdata_i   (prd_wdata_i[c]),
      .at_zero_i (zero_o[c]),
      .prd_nxt_o (prd_nxt[c]),
      .prd_act_o (prd_act[c])
    );

    pwm_phase_load #(.CNT_W(CNT_W)) u_ld (
      .phase_i (phase_i[c]),
      .dir_i   (phase_dir_i[c]),
      .prd_i   (prd_nxt[c]),
      .val_o   (ld_val[c]),
      .dir_o   (ld_dir[c])
    );

    pwm_updown_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .prd_i      (prd_nxt[c]),
      .load_i     (ld_en[c]),
      .load_val_i (ld_val[c]),
      .load_dir_i (ld_dir[c]),
      .cnt_o      (cnt_o[c]),
      .dir_o      (dir_o[c])
    );

    assign zero_o[c] = (cnt_o[c] == '0);
    assign prd_o[c]  = (cnt_o[c] == prd_act[c]);

    if (c == 0) begin : g_master
      assign ld_en[c]  = 1'b0;
      assign sync_o[c] = zero_o[c];
    end else begin : g_slave
      assign ld_en[c]  = phase_en_i[c] & sync_o[c-1];
      assign sync_o[c] = sync_o[c-1];
    end
  end

  p_chain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o[LastCh] == zero_o[0]);

  p_master_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o[0] && prd_nxt[0] != '0) |=> cnt_o[0] == CNT_W'(1));

  p_peak_down_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prd_o[0] && !zero_o[0]) |-> dir_o[0] == DIR_DOWN);
endmodule

// File: tb/phase_pwm_timebase_tb_top.sv
module phase_pwm_timebase_tb_top;
  localparam int N = 4;
  localparam int W = 16;
  localparam int P = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]        prd_wr = '0;
  logic [N-1:0][W-1:0] prd_wdata = '0;
  logic [N-1:0][W-1:0] phase = '0;
  logic [N-1:0]        pdir = '0;
  logic [N-1:0]        pen = '0;
  logic [N-1:0][W-1:0] cnt;
  logic [N-1:0]        dir, zero, prd, sync;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  phase_pwm_timebase #(.N_CH(N), .CNT_W(W), .RST_PRD(P)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .prd_wr_i(prd_wr), .prd_wdata_i(prd_wdata),
    .phase_i(phase), .phase_dir_i(pdir), .phase_en_i(pen),
    .cnt_o(cnt), .dir_o(dir), .zero_o(zero), .prd_o(prd), .sync_o(sync)
  );

  // reference model built from the requirements
  int m_cnt[N], m_dir[N], m_pa[N], m_sh[N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < N; c++) begin
        m_cnt[c] <= 0; m_dir[c] <= 1; m_pa[c] <= P; m_sh[c] <= P;
      end
    end else begin
      for (int c = 0; c < N; c++) begin
        int pn, v;
        pn = (m_cnt[c] == 0) ? m_sh[c] : m_pa[c];
        m_pa[c] <= pn;
        if (prd_wr[c]) m_sh[c] <= int'(prd_wdata[c]);
        if (c > 0 && pen[c] && m_cnt[0] == 0) begin
          v = (int'(phase[c]) > pn) ? pn : int'(phase[c]);
          m_cnt[c] <= v;
          m_dir[c] <= (v == 0) ? 1 : (v == pn) ? 0 : int'(pdir[c]);
        end else if (pn == 0) begin
          m_cnt[c] <= 0; m_dir[c] <= 1;
        end else if ((m_dir[c] == 1 && m_cnt[c] < pn) || m_cnt[c] == 0) begin
          m_cnt[c] <= m_cnt[c] + 1;
          m_dir[c] <= (m_cnt[c] + 1 >= pn) ? 0 : 1;
        end else begin
          m_cnt[c] <= m_cnt[c] - 1;
          m_dir[c] <= (m_cnt[c] - 1 == 0) ? 1 : 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock, then compare every channel against the model (R1 R2 R4 R5)
  task automatic step();
    @(negedge clk);
    for (int c = 0; c < N; c++) begin
      chk(int'(cnt[c]) == m_cnt[c], "R1 cnt", int'(cnt[c]), m_cnt[c]);
      chk(int'(dir[c]) == m_dir[c], "R1 dir", int'(dir[c]), m_dir[c]);
      chk(int'(cnt[c]) <= m_pa[c], "R2 range", int'(cnt[c]), m_pa[c]);
      chk(zero[c] == (m_cnt[c] == 0), "R4 zero", int'(zero[c]), int'(m_cnt[c] == 0));
      chk(prd[c] == (m_cnt[c] == m_pa[c]), "R4 prd", int'(prd[c]), int'(m_cnt[c] == m_pa[c]));
      chk(sync[c] == (m_cnt[0] == 0), "R5 sync", int'(sync[c]), int'(m_cnt[0] == 0));
    end
  endtask

  task automatic to_master_zero();
    for (int i = 0; i < 64 && cnt[0] != 0; i++) step();
  endtask

  task automatic t_reset();
    for (int c = 0; c < N; c++) begin
      chk(cnt[c] == 0, "R10 cnt", int'(cnt[c]), 0);
      chk(dir[c] == 1'b1, "R10 dir", int'(dir[c]), 1);
    end
  endtask

  task automatic t_carrier();
    repeat (P) step();
    chk(cnt[0] == P, "R1 peak", int'(cnt[0]), P);
    chk(prd[0] && !dir[0], "R4 peak flag", int'({prd[0], dir[0]}), 2);
    chk(cnt[0] == P, "R10 period", int'(cnt[0]), P);
    repeat (P) step();
    chk(cnt[0] == 0 && zero[0], "R1 trough", int'(cnt[0]), 0);
    chk(sync == '1, "R5 all sync", int'(sync), 15);
  endtask

  task automatic t_quadrature();
    to_master_zero();
    phase[1] = W'(P/2); pdir[1] = 1'b0;
    phase[2] = W'(P);   pdir[2] = 1'b1;
    phase[3] = W'(P/2); pdir[3] = 1'b1;
    pen = 4'b1110;
    for (int k = 0; k < 2; k++) begin
      step();
      chk(cnt[0] == 1 && dir[0], "R11 master", int'(cnt[0]), 1);
      chk(cnt[1] == P/2 && !dir[1], "R11 quarter", int'(cnt[1]), P/2);
      chk(cnt[2] == P && !dir[2], "R7 half forced down", int'({cnt[2], dir[2]}), P*2);
      chk(cnt[3] == P/2 && dir[3], "R11 three quarter", int'(cnt[3]), P/2);
      repeat (2*P - 1) step();
      chk(cnt[0] == 0, "R11 period", int'(cnt[0]), 0);
      chk(cnt[3] == P/2 - 1 && dir[3], "R6 steady slave", int'(cnt[3]), P/2 - 1);
    end
  endtask

  task automatic t_edges();
    to_master_zero();
    phase[0] = W'(5); pen[0] = 1'b1;
    phase[1] = '0;    pdir[1] = 1'b0;
    phase[2] = W'(20); pdir[2] = 1'b1;
    phase[3] = W'(6); pdir[3] = 1'b0; pen[3] = 1'b0;
    step();
    chk(cnt[0] == 1, "R8 master no load", int'(cnt[0]), 1);
    chk(cnt[1] == 0 && dir[1], "R7 zero forced up", int'({cnt[1], dir[1]}), 1);
    chk(cnt[2] == P && !dir[2], "R6 clamp", int'(cnt[2]), P);
    chk(cnt[3] == P/2 && dir[3], "R9 free run", int'(cnt[3]), P/2);
    pen = 4'b0110;
    repeat (2*P) step();
  endtask

  task automatic t_shadow();
    int mx;
    to_master_zero();
    step();
    prd_wr[0] = 1'b1; prd_wdata[0] = W'(4);
    step();
    prd_wr[0] = 1'b0;
    mx = 0;
    for (int i = 0; i < 64 && cnt[0] != 0; i++) begin
      if (int'(cnt[0]) > mx) mx = int'(cnt[0]);
      step();
    end
    chk(mx == P, "R3 old period held", mx, P);
    repeat (4) step();
    chk(cnt[0] == 4 && prd[0] && !dir[0], "R3 new period", int'(cnt[0]), 4);
    repeat (4) step();
    chk(cnt[0] == 0, "R3 new carrier", int'(cnt[0]), 0);
    repeat (3*P) step();
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_carrier();
    t_quadrature();
    t_edges();
    t_shadow();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule